// File: doc/BRIEF.md
# Quality-Parameter Coefficient Quantizer

This block quantizes the coefficients of a 4x4 integer transform. It takes one signed coefficient per clock, along with its row and column in the block, and returns one signed level. The transform stage upstream is built only from shifts and adds. Its normalisation is applied here instead, as a multiplication by a scale factor. That factor depends on the coefficient's position and on a 6-bit quality parameter.

The quality parameter `qp` is first limited to 51. The limited value is then split into `qp mod 6`, which picks the multiplier, and `qp / 6`, which sets the right shift of `15 + qp/6`. A lower `qp` gives a smaller shift, so the steps are finer and the quality is higher. The magnitude is rounded with an offset of one third of a step, as for intra blocks. The sign is put back after rounding.

Both sides use valid/ready handshakes. A transfer happens on a rising edge where valid and ready are both high. The input side is ready whenever the last pipeline stage is empty or its level is being taken in that cycle. So when `out_ready` is low and a level is pending, `in_ready` is low and the whole pipeline holds. A producer must keep `in_coef`, `in_row`, `in_col` and `qp` stable while `in_valid` is high and `in_ready` is low. The block keeps a pending output stable until it is accepted. `qp` is a plain control pin, sampled together with each accepted coefficient.

Top module: `qz_quantizer`

## Requirements
- R1: A `qp` value from 52 to 63 gives exactly the same level as `qp` = 51.
- R2: The multiplier is selected by `qp mod 6` (r = 0..5) and by position class. The class is "even" when row and column are both even, "odd" when both are odd, and "mixed" otherwise. The multipliers are: even 13107, 11916, 10082, 9362, 8192, 7282; odd 5243, 4660, 4194, 3647, 3355, 2893; mixed 8066, 7490, 6554, 5825, 5243, 4559.
- R3: With s = 15 + qp/6, the level magnitude is floor((|c|·MF + floor(2^s/3)) / 2^s). This bounds the magnitude by 13107 for a 16-bit input.
- R4: A negative coefficient yields the negated level of its magnitude. A zero input yields 0. The input -32768 is handled without overflow.
- R5: When `out_ready` is held high, `in_ready` stays high and a coefficient is accepted on every clock.
- R6: A coefficient accepted on rising edge n appears with `out_valid` high after edge n+2, provided `in_ready` is high at edges n+1 and n+2.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_level` hold their values and `in_ready` is low.
- R8: While `rst_n` is low, and after its release until a coefficient has passed through, `out_valid` is low.
- R9: Levels leave in the order their coefficients were accepted, with none lost or duplicated.
- R10: Each coefficient uses the `qp` sampled at its own acceptance, even when `qp` changes on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Coefficient present |
| in_ready | output | 1 | Block can take a coefficient |
| in_coef | input | CW (16) | Signed transform coefficient |
| in_row | input | 2 | Row of the coefficient in the 4x4 block |
| in_col | input | 2 | Column of the coefficient in the 4x4 block |
| qp | input | QPW (6) | Quality parameter, limited to 51 |
| out_valid | output | 1 | Quantized level present |
| out_ready | input | 1 | Consumer takes the level |
| out_level | output | LW (16) | Signed quantized level |

## Verification
A level is due three register stages after its coefficient is accepted, so it shows up two edges after the accepting edge. The bench drives inputs just after a rising edge and samples everything at the falling edge. At that sample it records each accepted coefficient together with its cycle number, then compares each delivered level in order against a behavioural model. In phases where `out_ready` is held high, the bench also requires the delivered level to appear exactly three falling-edge samples after its acceptance. With random back-pressure, any level held across a stalled sample must be unchanged at the next sample.

// File: rtl/qz_pkg.sv
package qz_pkg;

  typedef enum logic [1:0] {
    PC_EVEN  = 2'd0,
    PC_ODD   = 2'd1,
    PC_MIXED = 2'd2
  } pos_class_t;

  localparam int QP_LIMIT    = 51;
  localparam int QSHIFT_BASE = 15;
  localparam int MF_W        = 14;
  localparam int QB_W        = 5;

  // scale factor by position class and qp remainder
  function automatic logic [MF_W-1:0] mf_lookup(input logic [1:0] cls, input logic [2:0] rem);
    logic [MF_W-1:0] v;
    v = '0;
    case (cls)
      PC_EVEN: case (rem)
        3'd0: v = 14'd13107; 3'd1: v = 14'd11916; 3'd2: v = 14'd10082;
        3'd3: v = 14'd9362;  3'd4: v = 14'd8192;  3'd5: v = 14'd7282;
        default: v = '0;
      endcase
      PC_ODD: case (rem)
        3'd0: v = 14'd5243;  3'd1: v = 14'd4660;  3'd2: v = 14'd4194;
        3'd3: v = 14'd3647;  3'd4: v = 14'd3355;  3'd5: v = 14'd2893;
        default: v = '0;
      endcase
      PC_MIXED: case (rem)
        3'd0: v = 14'd8066;  3'd1: v = 14'd7490;  3'd2: v = 14'd6554;
        3'd3: v = 14'd5825;  3'd4: v = 14'd5243;  3'd5: v = 14'd4559;
        default: v = '0;
      endcase
      default: v = '0;
    endcase
    return v;
  endfunction

  // floor(2^qb / 3): the alternating 0101 pattern shifted into place
  function automatic logic [31:0] third_of_step(input logic [QB_W-1:0] qb);
    return 32'h5555_5555 >> (6'd32 - {1'b0, qb});
  endfunction

endpackage

// File: rtl/qz_qp_prep.sv
module qz_qp_prep
  import qz_pkg::*;
#(
  parameter int QPW = 6
) (
  input  logic [QPW-1:0]  qp_raw,
  output logic [2:0]      rem,
  output logic [QB_W-1:0] qbits
);
  localparam logic [QPW-1:0] LIMIT = QPW'(QP_LIMIT);

  logic [QPW-1:0] qp_eff;
  int             qv;

  always_comb begin
    qp_eff = (qp_raw > LIMIT) ? LIMIT : qp_raw;
    qv     = int'(qp_eff);
    rem    = 3'(qv % 6);
    qbits  = QB_W'(QSHIFT_BASE + qv / 6);
  end
endmodule

// File: rtl/qz_mf_table.sv
module qz_mf_table
  import qz_pkg::*;
(
  input  logic [1:0]      row,
  input  logic [1:0]      col,
  input  logic [2:0]      rem,
  output logic [MF_W-1:0] mf
);
  localparam int NCLS = 4;

  logic [1:0]      cls;
  logic [MF_W-1:0] cand [NCLS];

  always_comb begin
    if (row[0] != col[0])  cls = PC_MIXED;
    else if (row[0])       cls = PC_ODD;
    else                   cls = PC_EVEN;
  end

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    assign cand[g] = mf_lookup(2'(g), rem);
  end

  assign mf = cand[cls];
endmodule

// File: rtl/qz_round_shift.sv
module qz_round_shift
  import qz_pkg::*;
#(
  parameter int SUMW = 30,
  parameter int LW   = 16
) (
  input  logic [SUMW-1:0]        sum,
  input  logic [QB_W-1:0]        qbits,
  input  logic                   neg,
  output logic signed [LW-1:0]   level
);
  logic [SUMW-1:0]   shifted;
  logic signed [SUMW:0] wide;

  always_comb begin
    shifted = sum >> qbits;
    wide    = neg ? -$signed({1'b0, shifted}) : $signed({1'b0, shifted});
    level   = LW'(wide);
  end
endmodule

// File: rtl/qz_quantizer.sv
module qz_quantizer
  import qz_pkg::*;
#(
  parameter int CW  = 16,
  parameter int LW  = 16,
  parameter int QPW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [CW-1:0] in_coef,
  input  logic [1:0]           in_row,
  input  logic [1:0]           in_col,
  input  logic [QPW-1:0]       qp,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [LW-1:0] out_level
);
  localparam int PW = CW + MF_W;

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // stage 0 (combinational): magnitude, sign, qp split, scale factor
  logic [CW-1:0]   coef_bits, coef_mag;
  logic            coef_neg;
  logic [2:0]      qp_rem;
  logic [QB_W-1:0] qp_shift;
  logic [MF_W-1:0] mf_sel;

  always_comb begin
    coef_bits = in_coef;
    coef_neg  = coef_bits[CW-1];
    coef_mag  = coef_neg ? (~coef_bits + 1'b1) : coef_bits;
  end

  qz_qp_prep #(.QPW(QPW)) u_qp (
    .qp_raw (qp),
    .rem    (qp_rem),
    .qbits  (qp_shift)
  );

  qz_mf_table u_mf (
    .row (in_row),
    .col (in_col),
    .rem (qp_rem),
    .mf  (mf_sel)
  );

  // stage 1 registers
  logic            s1_v, s1_neg;
  logic [CW-1:0]   s1_mag;
  logic [MF_W-1:0] s1_mf;
  logic [QB_W-1:0] s1_qb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_neg <= 1'b0; s1_mag <= '0; s1_mf <= '0; s1_qb <= '0;
    end else if (adv) begin
      s1_v   <= in_valid;
      s1_neg <= coef_neg;
      s1_mag <= coef_mag;
      s1_mf  <= mf_sel;
      s1_qb  <= qp_shift;
    end
  end

  // stage 2 registers: scaled magnitude plus rounding offset
  logic            s2_v, s2_neg;
  logic [PW-1:0]   s2_sum;
  logic [QB_W-1:0] s2_qb;
  logic [PW-1:0]   prod, offs;

  always_comb begin
    prod = PW'(s1_mag) * PW'(s1_mf);
    offs = PW'(third_of_step(s1_qb));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_neg <= 1'b0; s2_sum <= '0; s2_qb <= '0;
    end else if (adv) begin
      s2_v   <= s1_v;
      s2_neg <= s1_neg;
      s2_sum <= prod + offs;
      s2_qb  <= s1_qb;
    end
  end

  // stage 3: shift, restore sign, output register
  logic signed [LW-1:0] lvl_next;

  qz_round_shift #(.SUMW(PW), .LW(LW)) u_rs (
    .sum   (s2_sum),
    .qbits (s2_qb),
    .neg   (s2_neg),
    .level (lvl_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_level <= '0;
    end else if (adv) begin
      out_valid <= s2_v;
      out_level <= lvl_next;
    end
  end
endmodule

// File: rtl/qz_quantizer_chk.sv
module qz_quantizer_chk #(
  parameter int CW = 16,
  parameter int LW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [LW-1:0] out_level
);
  localparam longint MAXL = ((longint'(1) << (CW - 1)) * 13107 + ((longint'(1) << 15) / 3)) >> 15;

  p_reset_r8: assert property (@(posedge clk) !rst_n |-> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_level)));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready ##1 in_ready |=> out_valid);

  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'(out_level) <= MAXL && longint'(out_level) >= -MAXL));
endmodule

bind qz_quantizer qz_quantizer_chk #(.CW(CW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_level (out_level)
);

// File: tb/sim_qz_quantizer.sv
module sim_qz_quantizer;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic signed [15:0] in_coef = '0;
  logic [1:0]        in_row = '0;
  logic [1:0]        in_col = '0;
  logic [5:0]        qp = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic signed [15:0] out_level;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  int ready_low = 0;
  string cur_tag = "R2";

  int    exp_q[$];
  int    cyc_q[$];
  bit    strict_q[$];
  string tag_q[$];

  bit hold_pend = 1'b0;
  int held_lvl  = 0;

  always #4 clk = ~clk;

  qz_quantizer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_row(in_row), .in_col(in_col), .qp(qp),
    .out_valid(out_valid), .out_ready(out_ready), .out_level(out_level)
  );

  function automatic int ref_level(int c, int r, int k, int q);
    int qe, rem, sh, mf, cls;
    longint mag, lv;
    qe  = (q > 51) ? 51 : q;
    rem = qe % 6;
    sh  = 15 + qe / 6;
    if ((r % 2) != (k % 2)) cls = 2;
    else if ((r % 2) == 1) cls = 1;
    else cls = 0;
    case (cls)
      0: case (rem) 0: mf = 13107; 1: mf = 11916; 2: mf = 10082; 3: mf = 9362; 4: mf = 8192; default: mf = 7282; endcase
      1: case (rem) 0: mf = 5243; 1: mf = 4660; 2: mf = 4194; 3: mf = 3647; 4: mf = 3355; default: mf = 2893; endcase
      default: case (rem) 0: mf = 8066; 1: mf = 7490; 2: mf = 6554; 3: mf = 5825; 4: mf = 5243; default: mf = 4559; endcase
    endcase
    mag = (c < 0) ? -longint'(c) : longint'(c);
    lv  = (mag * mf + ((longint'(1) << sh) / 3)) >> sh;
    return (c < 0) ? -int'(lv) : int'(lv);
  endfunction

  task automatic chk(bit ok, string tag, int got, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, expv, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // out_ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = stall_mode ? 1'($urandom % 2) : 1'b1;
    end
  end

  // monitor at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(out_valid == 1'b0, "R8 reset", int'(out_valid), 0);
    end else begin
      if (!stall_mode && !in_ready) ready_low++;
      if (hold_pend)
        chk(out_valid && int'(out_level) == held_lvl, "R7 hold", int'(out_level), held_lvl);
      hold_pend = out_valid && !out_ready;
      held_lvl  = int'(out_level);
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_level(int'(in_coef), int'(in_row), int'(in_col), int'(qp)));
        cyc_q.push_back(cyc);
        strict_q.push_back(!stall_mode);
        tag_q.push_back(cur_tag);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 extra output", int'(out_level), 0);
        end else begin
          int e, c0;
          bit s;
          string t;
          e = exp_q.pop_front(); c0 = cyc_q.pop_front();
          s = strict_q.pop_front(); t = tag_q.pop_front();
          chk(int'(out_level) == e, t, int'(out_level), e);
          if (s) chk(cyc - c0 == 3, "R6 latency", cyc - c0, 3);
        end
      end
    end
  end

  task automatic send(int c, int r, int k, int q);
    bit acc;
    in_valid = 1'b1;
    in_coef  = 16'(c);
    in_row   = 2'(r);
    in_col   = 2'(k);
    qp       = 6'(q);
    forever begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 after release", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8 ready after release", int'(in_ready), 1);
    @(posedge clk); #1;

    // R2: every class and every remainder, back to back
    cur_tag = "R2 multiplier";
    for (int q = 0; q < 6; q++) begin
      send(1000, 0, 2, q);
      send(-1000, 1, 3, q);
      send(1000, 2, 1, q);
    end
    // R3: shift grows with qp/6; small values probe rounding
    cur_tag = "R3 shift+offset";
    for (int q = 0; q <= 48; q += 6) begin
      send(12345, 2, 2, q);
      send(3, 0, 0, q);
      send(-7, 3, 0, q + 3);
    end
    // R1: clamp above 51
    cur_tag = "R1 clamp";
    for (int q = 50; q < 64; q++) send(-20000, 3, 1, q);
    // R4: sign and extremes
    cur_tag = "R4 sign";
    send(0, 0, 0, 0);
    send(-1, 0, 0, 0);
    send(1, 0, 0, 0);
    send(-32768, 0, 0, 0);
    send(32767, 0, 0, 0);
    send(-32768, 1, 1, 63);
    drain();
    // R5: no stall cycles while out_ready high
    chk(ready_low == 0, "R5 throughput", ready_low, 0);

    // R10/R9: random back-pressure and qp changing every coefficient
    stall_mode = 1'b1;
    cur_tag = "R10 per-coefficient qp";
    for (int i = 0; i < 300; i++)
      send(int'($urandom % 65536) - 32768, int'($urandom % 4), int'($urandom % 4), int'($urandom % 64));
    stall_mode = 1'b0;
    drain();
    chk(exp_q.size() == 0, "R9 nothing lost", exp_q.size(), 0);
    chk(out_valid == 1'b0, "R9 idle after drain", int'(out_valid), 0);

    done = 1'b1;
    finish_run();
  end
endmodule